// File: doc/BRIEF.md
# Byte-Wide SPI Port with Flag Handshake

This block attaches an 8-bit SPI link to a small processor bus. Software sees three registers through a strobe-based port with a 2-bit address: a control register at address 0, a status register at address 1 and a data register at address 2. In master mode the block generates the serial clock itself, dividing the bus clock by one of four ratios. In slave mode an external master supplies the clock and frames each byte with an active-low select.

When a byte has been exchanged, a completion flag rises and, if enabled, requests an interrupt. The flag is not cleared by a single access. Software first reads status while a flag is up, which arms the clear. The next read or write of the data register then drops the completion and collision flags. Until that status read has happened, a pending completion flag blocks every write to the data register. This keeps software from overwriting a byte it has not yet acknowledged.

Control fields: bit 7 interrupt enable, bit 6 block enable, bit 4 master select, bit 3 clock polarity, bit 2 clock phase, bits 1:0 rate code. Status fields: bit 7 transfer complete, bit 6 write collision, bit 4 mode fault. All other status bits read as zero.

Top module: `spi_byte_port`

## Requirements
- R1: After reset the control and status registers read 0x00, irq is low and sckOut is low.
- R2: In master mode rate codes 0, 1, 2 and 3 give an SCK period of 2, 4, 16 and 32 bus clocks, so each half period lasts 1, 2, 8 or 16 bus clocks.
- R3: A master data write sends the byte MSB first. The same byte is received from misoIn. SCK idles at the polarity bit (control bit 3). Data is sampled on the leading SCK edge when the phase bit (control bit 2) is 0, and on the trailing edge when it is 1. This holds in all four modes.
- R4: Status bit 7 sets once the eighth bit of a byte has been exchanged.
- R5: irq is high exactly while status bit 7 is set and control bit 7 is set.
- R6: Status bits 7 and 6 clear only after a status read made while a flag is set, followed by a read or write of the data register. A data access without that prior status read leaves them set.
- R7: While status bit 7 is set and no status read has armed the clear, a data register write is ignored and starts no transfer. After the arming status read, the same write is accepted.
- R8: A data write during a transfer sets status bit 6, and the byte in flight is unchanged. The bit clears through the same handshake as bit 7.
- R9: If the synchronized select input is low while enabled as master, status bit 4 sets and control bit 4 reads 0. A status read with bit 4 set, followed by a control write, clears bit 4.
- R10: In slave mode a byte is exchanged MSB first while ssN is low. The first SCK edge samples the first bit when the phase is 0. With phase 1 the first edge launches data and the trailing edges sample. The received byte then reads from the data register, and the rate code has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register select: 0 control, 1 status, 2 data |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sckOut | output | 1 | Serial clock driven in master mode |
| mosiOut | output | 1 | Serial data out in master mode |
| misoIn | input | 1 | Serial data in for master mode |
| sckIn | input | 1 | Serial clock from an external master |
| mosiIn | input | 1 | Serial data in for slave mode |
| misoOut | output | 1 | Serial data out in slave mode |
| misoOe | output | 1 | Output enable for misoOut |
| ssN | input | 1 | Active-low select |

## Verification
A fault in the handshake state shows at the ports in one of two ways. Either irq stays high after the acknowledging data access, or a transfer starts or fails to start within a cycle of a data write. Both are visible at the very next bus access. An off-by-one in the edge counter or the sample/launch choice shows on the next data read as a rotated or shifted byte, and on mosiOut or misoOut as a wrong bit at a sampling edge. A divider fault shows in the first SCK half period after a write.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  // Strobes and configuration from control to datapath
  typedef struct packed {
    logic              load;
    logic [DATA_W-1:0] txByte;
    logic              enable;
    logic              master;
    logic              cpol;
    logic              cpha;
    logic [1:0]        rate;
  } spiCmd_t;
endpackage

// File: rtl/spi_port_dpath.sv
`timescale 1ns/1ps
module spi_port_dpath
  import spi_port_pkg::*;
#(
  parameter int DIV_R0 = 2,
  parameter int DIV_R1 = 4,
  parameter int DIV_R2 = 16,
  parameter int DIV_R3 = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiCmd_t           cmd,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              ssN,
  input  logic              misoIn,
  output logic              sckOut,
  output logic              mosiOut,
  output logic              misoOut,
  output logic              misoOe,
  output logic              busy,
  output logic              doneP,
  output logic              ssLow,
  output logic [DATA_W-1:0] rxByte
);
  localparam int HALF_MAX  = DIV_R3 / 2;
  localparam int DIVW      = $clog2(HALF_MAX) + 1;
  localparam int EDGES     = 2 * DATA_W;
  localparam int ECW       = $clog2(EDGES);
  localparam logic [ECW-1:0] LAST_EDGE = ECW'(EDGES - 1);

  logic [2:0]        sckSy;
  logic [1:0]        mosiSy;
  logic [1:0]        ssSy;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] rxReg;
  logic [DATA_W-1:0] nextSh;
  logic              outBit;
  logic              busyR;
  logic              doneR;
  logic              sckPh;
  logic [DIVW-1:0]   divCnt;
  logic [DIVW-1:0]   halfM1;
  logic [ECW-1:0]    edgeCnt;
  logic              atTerm;
  logic              mstEdge;
  logic              slvEdge;
  logic              edgeNow;
  logic              sampleNow;
  logic              rxBit;

  // Half-period length selected by the rate code (master only)
  always_comb begin
    case (cmd.rate)
      2'd0:    halfM1 = DIVW'(DIV_R0 / 2 - 1);
      2'd1:    halfM1 = DIVW'(DIV_R1 / 2 - 1);
      2'd2:    halfM1 = DIVW'(DIV_R2 / 2 - 1);
      default: halfM1 = DIVW'(DIV_R3 / 2 - 1);
    endcase
  end

  assign ssLow     = ~ssSy[1];
  assign atTerm    = divCnt >= halfM1;
  assign mstEdge   = cmd.master && busyR && atTerm;
  assign slvEdge   = !cmd.master && cmd.enable && ssLow && (sckSy[2] ^ sckSy[1]);
  assign edgeNow   = cmd.master ? mstEdge : slvEdge;
  assign sampleNow = edgeNow && (edgeCnt[0] == cmd.cpha);
  assign rxBit     = cmd.master ? misoIn : mosiSy[1];
  assign nextSh    = sampleNow ? {shreg[DATA_W-2:0], rxBit} : shreg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSy   <= '0;
      mosiSy  <= '0;
      ssSy    <= 2'b11;
      shreg   <= '0;
      rxReg   <= '0;
      outBit  <= 1'b0;
      busyR   <= 1'b0;
      doneR   <= 1'b0;
      sckPh   <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
    end else begin
      sckSy  <= {sckSy[1:0], sckIn};
      mosiSy <= {mosiSy[0], mosiIn};
      ssSy   <= {ssSy[0], ssN};
      doneR  <= 1'b0;
      if (cmd.load) begin
        shreg   <= cmd.txByte;
        outBit  <= cmd.txByte[DATA_W-1];
        edgeCnt <= '0;
        divCnt  <= '0;
        sckPh   <= 1'b0;
        if (cmd.master) busyR <= 1'b1;
      end else begin
        if (cmd.master && busyR) divCnt <= atTerm ? '0 : divCnt + 1'b1;
        if (edgeNow) begin
          edgeCnt <= edgeCnt + 1'b1;
          busyR   <= 1'b1;
          if (cmd.master) sckPh <= ~sckPh;
          if (sampleNow) shreg  <= nextSh;
          else           outBit <= shreg[DATA_W-1];
          if (edgeCnt == LAST_EDGE) begin
            busyR   <= 1'b0;
            edgeCnt <= '0;
            doneR   <= 1'b1;
            rxReg   <= nextSh;
          end
        end
        if (!cmd.master) begin
          sckPh <= 1'b0;
          if (!ssLow) begin
            edgeCnt <= '0;
            busyR   <= 1'b0;
          end
        end
      end
    end
  end

  assign sckOut  = cmd.cpol ^ sckPh;
  assign mosiOut = outBit;
  assign misoOut = outBit;
  assign misoOe  = !cmd.master && cmd.enable && ssLow;
  assign busy    = busyR;
  assign doneP   = doneR;
  assign rxByte  = rxReg;

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyR && cmd.master) |-> (sckOut == cmd.cpol));

  // R4
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneR |-> $past(busyR));
endmodule

// File: rtl/spi_port_ctrl.sv
`timescale 1ns/1ps
module spi_port_ctrl
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output spiCmd_t           cmd,
  input  logic              busyIn,
  input  logic              doneIn,
  input  logic              ssLowIn,
  input  logic [DATA_W-1:0] rxIn
);
  logic       ctlIe, ctlEn, ctlMstr, ctlCpol, ctlCpha;
  logic [1:0] ctlRate;
  logic       doneF, wcolF, modfF, armed;
  logic       stRd, dAcc, dWr, cWr, anyFlag, wrAllowed;
  logic       unusedWbit;

  assign unusedWbit = busWdata[5];

  assign stRd      = busRd && (busAddr == ADDR_STAT);
  assign dAcc      = (busRd || busWr) && (busAddr == ADDR_DATA);
  assign dWr       = busWr && (busAddr == ADDR_DATA);
  assign cWr       = busWr && (busAddr == ADDR_CTL);
  assign anyFlag   = doneF || wcolF || modfF;
  assign wrAllowed = !doneF || armed;

  always_comb begin
    cmd.load   = dWr && wrAllowed && !busyIn && ctlEn;
    cmd.txByte = busWdata;
    cmd.enable = ctlEn;
    cmd.master = ctlMstr;
    cmd.cpol   = ctlCpol;
    cmd.cpha   = ctlCpha;
    cmd.rate   = ctlRate;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlIe   <= 1'b0;
      ctlEn   <= 1'b0;
      ctlMstr <= 1'b0;
      ctlCpol <= 1'b0;
      ctlCpha <= 1'b0;
      ctlRate <= 2'b00;
      doneF   <= 1'b0;
      wcolF   <= 1'b0;
      modfF   <= 1'b0;
      armed   <= 1'b0;
    end else begin
      if (cWr) begin
        ctlIe   <= busWdata[7];
        ctlEn   <= busWdata[6];
        ctlMstr <= busWdata[4] && (!modfF || armed);
        ctlCpol <= busWdata[3];
        ctlCpha <= busWdata[2];
        ctlRate <= busWdata[1:0];
        if (armed) modfF <= 1'b0;
      end
      if (ctlEn && ctlMstr && ssLowIn) begin
        modfF   <= 1'b1;
        ctlMstr <= 1'b0;
      end
      if (dAcc && armed) begin
        doneF <= 1'b0;
        wcolF <= 1'b0;
        armed <= 1'b0;
      end
      if (stRd && anyFlag) armed <= 1'b1;
      if (dWr && busyIn)   wcolF <= 1'b1;
      if (doneIn)          doneF <= 1'b1;
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_CTL:  busRdata = {ctlIe, ctlEn, 1'b0, ctlMstr, ctlCpol, ctlCpha, ctlRate};
      ADDR_STAT: busRdata = {doneF, wcolF, 1'b0, modfF, 4'b0000};
      ADDR_DATA: busRdata = rxIn;
      default:   busRdata = '0;
    endcase
  end

  assign irq = doneF && ctlIe;

  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doneF) |-> $past(armed));

  // R7
  wr_inhibit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dWr && doneF && !armed && !busyIn && ctlMstr) |=> !busyIn);

  // R8
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dWr && busyIn) |=> wcolF);

  // R9
  modf_master_chk: assert property (@(posedge clk) disable iff (!rstN)
    modfF |-> !ctlMstr);
endmodule

// File: rtl/spi_byte_port.sv
`timescale 1ns/1ps
module spi_byte_port
  import spi_port_pkg::*;
#(
  parameter int DIV_R0 = 2,
  parameter int DIV_R1 = 4,
  parameter int DIV_R2 = 16,
  parameter int DIV_R3 = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output logic              sckOut,
  output logic              mosiOut,
  input  logic              misoIn,
  input  logic              sckIn,
  input  logic              mosiIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              ssN
);
  spiCmd_t           cmd;
  logic              busy;
  logic              doneP;
  logic              ssLow;
  logic [DATA_W-1:0] rxByte;

  spi_port_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busRd    (busRd),
    .busWr    (busWr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irq      (irq),
    .cmd      (cmd),
    .busyIn   (busy),
    .doneIn   (doneP),
    .ssLowIn  (ssLow),
    .rxIn     (rxByte)
  );

  spi_port_dpath #(
    .DIV_R0 (DIV_R0),
    .DIV_R1 (DIV_R1),
    .DIV_R2 (DIV_R2),
    .DIV_R3 (DIV_R3)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .sckIn   (sckIn),
    .mosiIn  (mosiIn),
    .ssN     (ssN),
    .misoIn  (misoIn),
    .sckOut  (sckOut),
    .mosiOut (mosiOut),
    .misoOut (misoOut),
    .misoOe  (misoOe),
    .busy    (busy),
    .doneP   (doneP),
    .ssLow   (ssLow),
    .rxByte  (rxByte)
  );
endmodule

// File: tb/spi_byte_port_tb.sv
`timescale 1ns/1ps
module spi_byte_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SLV_HALF   = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busRd = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irq, sckOut, mosiOut, misoIn, misoOut, misoOe;
  logic       sckIn = 1'b0;
  logic       mosiIn = 1'b0;
  logic       ssN = 1'b1;

  int chkCnt = 0;
  int failCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign misoIn = mosiOut; // external loopback for master tests

  spi_byte_port u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .sckOut(sckOut),
    .mosiOut(mosiOut), .misoIn(misoIn), .sckIn(sckIn), .mosiIn(mosiIn),
    .misoOut(misoOut), .misoOe(misoOe), .ssN(ssN)
  );

  task automatic check(input string tag, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] d;
    busRead(2'd0, d); check("R1 control after reset", d, 8'h00);
    busRead(2'd1, d); check("R1 status after reset", d, 8'h00);
    check("R1 irq after reset", irq, 0);
    check("R1 sckOut after reset", sckOut, 0);
  endtask

  task automatic testRates();
    logic [7:0] d;
    logic s;
    int n;
    for (int code = 0; code < 4; code++) begin
      busWrite(2'd0, 8'h50 | 8'(code));
      busWrite(2'd2, 8'hA5);
      n = 0;
      while (sckOut == 1'b0 && n < 200) begin @(negedge clk); n++; end
      s = sckOut;
      n = 0;
      do begin @(negedge clk); n++; end while (sckOut == s && n < 200);
      check($sformatf("R2 half period code %0d", code), n, (code == 0) ? 1 : (code == 1) ? 2 : (code == 2) ? 8 : 16);
      waitClk(600);
      busRead(2'd1, d);
      busRead(2'd2, d);
    end
  endtask

  task automatic testMasterMode(input bit cpol, input bit cpha, input bit ie, input logic [7:0] tx);
    logic [7:0] d, bits;
    logic prev;
    int edges, nb, guard;
    busWrite(2'd0, {ie, 1'b1, 1'b0, 1'b1, cpol, cpha, 2'b01});
    waitClk(2);
    check($sformatf("R3 sck idle mode %0d", {cpol, cpha}), sckOut, cpol);
    busWrite(2'd2, tx);
    edges = 0; nb = 0; guard = 0; bits = '0;
    prev = sckOut;
    while (edges < 16 && guard < 500) begin
      @(negedge clk); guard++;
      if (sckOut != prev) begin
        edges++;
        if ((sckOut != cpol) == (cpha == 1'b0)) begin
          bits = {bits[6:0], mosiOut};
          nb++;
        end
        prev = sckOut;
      end
    end
    check($sformatf("R3 mosi bits mode %0d", {cpol, cpha}), bits, tx);
    waitClk(3);
    check($sformatf("R5 irq mode %0d", {cpol, cpha}), irq, ie);
    check($sformatf("R3 sck back idle mode %0d", {cpol, cpha}), sckOut, cpol);
    busRead(2'd1, d); check($sformatf("R4 done flag mode %0d", {cpol, cpha}), d, 8'h80);
    busRead(2'd2, d); check($sformatf("R3 loopback byte mode %0d", {cpol, cpha}), d, tx);
    busRead(2'd1, d); check($sformatf("R6 flag cleared mode %0d", {cpol, cpha}), d, 8'h00);
    check($sformatf("R5 irq low after clear mode %0d", {cpol, cpha}), irq, 0);
  endtask

  task automatic testHandshake();
    logic [7:0] d;
    int toggles;
    logic prev;
    busWrite(2'd0, 8'hD0);
    busWrite(2'd2, 8'h5A);
    waitClk(40);
    check("R5 irq after done", irq, 1);
    busRead(2'd2, d);
    waitClk(2);
    check("R6 data read alone keeps flag", irq, 1);
    busWrite(2'd2, 8'h3C);
    toggles = 0; prev = sckOut;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (sckOut != prev) toggles++;
      prev = sckOut;
    end
    check("R7 inhibited write starts no transfer", toggles, 0);
    check("R7 inhibited write keeps flag", irq, 1);
    busRead(2'd1, d); check("R6 status before clear", d, 8'h80);
    busWrite(2'd2, 8'h3C);
    check("R6 flag cleared by write after status read", irq, 0);
    waitClk(40);
    busRead(2'd1, d); check("R7 accepted write completes", d, 8'h80);
    busRead(2'd2, d); check("R7 accepted byte", d, 8'h3C);
    check("R6 irq low after handshake", irq, 0);
  endtask

  task automatic testCollision();
    logic [7:0] d;
    busWrite(2'd0, 8'h53);
    busWrite(2'd2, 8'h81);
    waitClk(10);
    busWrite(2'd2, 8'hFF);
    busRead(2'd1, d); check("R8 collision flag during transfer", d, 8'h40);
    waitClk(600);
    busRead(2'd1, d); check("R8 both flags after done", d, 8'hC0);
    busRead(2'd2, d); check("R8 byte in flight unchanged", d, 8'h81);
    busRead(2'd1, d); check("R8 collision cleared", d, 8'h00);
  endtask

  task automatic testModeFault();
    logic [7:0] d;
    busWrite(2'd0, 8'h50);
    ssN = 1'b0;
    waitClk(6);
    busRead(2'd1, d); check("R9 mode fault flag", d, 8'h10);
    busRead(2'd0, d); check("R9 master bit dropped", d, 8'h40);
    ssN = 1'b1;
    waitClk(4);
    busWrite(2'd0, 8'h00);
    busRead(2'd1, d); check("R9 mode fault cleared", d, 8'h00);
  endtask

  task automatic testSlave(input bit cpol, input bit cpha, input logic [1:0] rate,
                           input logic [7:0] slvTx, input logic [7:0] mstTx);
    logic [7:0] d, got;
    busWrite(2'd0, {2'b01, 2'b00, cpol, cpha, rate});
    sckIn = cpol; mosiIn = 1'b0;
    waitClk(4);
    busWrite(2'd2, slvTx);
    ssN = 1'b0;
    waitClk(SLV_HALF);
    check($sformatf("R10 miso enabled mode %0d", {cpol, cpha}), misoOe, 1);
    got = '0;
    for (int i = 7; i >= 0; i--) begin
      if (!cpha) begin
        mosiIn = mstTx[i];
        waitClk(SLV_HALF);
        got[i] = misoOut;
        sckIn = ~cpol;
        waitClk(SLV_HALF);
        sckIn = cpol;
      end else begin
        sckIn = ~cpol;
        mosiIn = mstTx[i];
        waitClk(SLV_HALF);
        got[i] = misoOut;
        sckIn = cpol;
        waitClk(SLV_HALF);
      end
    end
    waitClk(SLV_HALF);
    ssN = 1'b1;
    waitClk(6);
    check($sformatf("R10 slave miso bits mode %0d rate %0d", {cpol, cpha}, rate), got, slvTx);
    busRead(2'd1, d); check($sformatf("R10 slave done mode %0d", {cpol, cpha}), d, 8'h80);
    busRead(2'd2, d); check($sformatf("R10 slave rx byte rate %0d", rate), d, mstTx);
    busRead(2'd1, d); check($sformatf("R10 slave flag cleared mode %0d", {cpol, cpha}), d, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", chkCnt, failCnt);
    $finish;
  end

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(2);
    testReset();
    testRates();
    testMasterMode(1'b0, 1'b0, 1'b0, 8'hB4);
    testMasterMode(1'b0, 1'b1, 1'b1, 8'h1E);
    testMasterMode(1'b1, 1'b0, 1'b1, 8'hC9);
    testMasterMode(1'b1, 1'b1, 1'b1, 8'h67);
    testHandshake();
    testCollision();
    testModeFault();
    testSlave(1'b0, 1'b0, 2'd0, 8'h6B, 8'hD2);
    testSlave(1'b0, 1'b0, 2'd3, 8'h6B, 8'hD2);
    testSlave(1'b1, 1'b1, 2'd1, 8'h94, 8'h2F);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", chkCnt, failCnt);
    $finish;
  end
endmodule